// File: doc/BRIEF.md
# Command Handshake and Burst Splitter

This block sits between a client that wants to move a stream of data and a system bus that accepts fixed-length transfers. The client presents one command: a read or write request, a start address, a byte length, a flag that selects a single-beat or a burst transfer, and byte enables. The block turns that command into a series of bus requests. Each request is a single beat or a fixed-length burst of 2 to 16 beats. The bus answers every request with an address-phase acknowledge or a timeout, and it signals the end of each data phase, with or without an error.

The client gets one command acknowledge, for the first address phase only. It gets a single one-cycle completion pulse when the whole command has finished. Error and timeout flags accompany that pulse. The block does not post a request until the client's matching data stream is ready. A timeout on any address phase ends the command. It also forces the matching client stream to discontinue, and this can happen on a later child request, after the acknowledge has already been given. Bus arbitration and data-width conversion lie outside this block.

Top module: `burst_cmd_splitter`

## Requirements
- R1: From idle, a bus request is posted only while a read request is present with `rd_dst_ready` high, or a write request is present with `wr_src_ready` high. If both requests are present and both are ready, the read is taken. A request whose own stream is not ready leaves `bus_req` low, even when the other stream is ready.
- R2: A single-beat command (`cmd_burst`=0) produces exactly one bus request. That request has `bus_beats`=1, `bus_burst`=0 and `bus_be` equal to `cmd_be`, whatever the value of `cmd_len`. `bus_rnw` is 1 for a read and 0 for a write.
- R3: `st_cmd_ack` is high for exactly one cycle, the cycle after the first request's address-phase acknowledge. Acknowledges of later child requests never raise it.
- R4: A burst command of N = `cmd_len`/NATIVE_BYTES beats is split into pieces, taken in order. While more than 17 beats remain, the next piece is 16 beats. When exactly 17 remain, the next piece is 15 and the final piece is 2. When 16 or fewer remain, the next piece is the final one and takes all of them.
- R5: Each child request starts at the previous request's address plus its beat count times NATIVE_BYTES. The first request starts at `cmd_addr`.
- R6: Every burst request on the bus carries between 2 and 16 beats, and `bus_be` is all ones.
- R7: `st_cmplt` pulses for one cycle, in the cycle after the final data phase ends. `st_error` is high in that same cycle exactly when at least one data phase of the command ended with `bus_data_err`.
- R8: An address-phase timeout on any request ends the command at once. In the next cycle `st_timeout`, `st_error` and `st_cmplt` are all high, and so is `rd_discontinue` for a read or `wr_discontinue` for a write. There is no command acknowledge for that address phase.
- R9: `bus_req` is low in the cycle after a timeout. While a request waits with neither an acknowledge nor a timeout, `bus_req` and `bus_addr` hold steady.
- R10: After reset, every output is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_rd_req | input | 1 | Client read request, held until acknowledge |
| cmd_wr_req | input | 1 | Client write request, held until acknowledge |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Byte length for bursts, a multiple of NATIVE_BYTES |
| cmd_burst | input | 1 | 1 = fixed-length burst, 0 = single beat |
| cmd_be | input | NATIVE_BYTES | Byte enables for a single beat |
| rd_dst_ready | input | 1 | Client read stream can accept data |
| wr_src_ready | input | 1 | Client write stream has its first word present |
| bus_req | output | 1 | Request posted on the bus |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_addr | output | ADDR_W | Request start address |
| bus_be | output | NATIVE_BYTES | Request byte enables |
| bus_burst | output | 1 | Request is a burst |
| bus_beats | output | PIECE_W | Beats in this request |
| bus_addr_ack | input | 1 | Address-phase acknowledge |
| bus_timeout | input | 1 | Address-phase timeout |
| bus_data_done | input | 1 | Data phase of the current request has ended |
| bus_data_err | input | 1 | Data phase ended with an error (valid with done) |
| st_cmd_ack | output | 1 | Command acknowledge |
| st_cmplt | output | 1 | Command complete pulse |
| st_error | output | 1 | Error status, valid with complete |
| st_timeout | output | 1 | Timeout status, valid with complete |
| rd_discontinue | output | 1 | Read stream forced to discontinue |
| wr_discontinue | output | 1 | Write stream forced to discontinue |

## Verification
The bench builds the block with its defaults: a 4-byte native width, a 12-bit length and 16-beat maximum bursts. With these values every burst size from 2 to 40 beats can be swept in both directions, and the sweep covers the rebalanced 15+2 tail at 17 and 33 beats. The same build can run a full-length 1023-beat command made of 64 children. The small width keeps the expected piece sizes and child addresses simple arithmetic in the bench. Errors and timeouts are injected on the first request and on later child requests, and the readiness gate is tested with the wrong stream ready.

// File: rtl/burst_cmd_pkg.sv
package burst_cmd_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_REQ  = 2'd1,
    CTL_DATA = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/burst_piece_calc.sv
module burst_piece_calc #(
  parameter int MAX_BEATS = 16,
  parameter int CNT_W     = 11,
  parameter int PIECE_W   = 5
) (
  input  logic [CNT_W-1:0]   remaining,
  output logic [PIECE_W-1:0] piece
);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_BEATS);
  localparam logic [CNT_W-1:0] TAIL_C = CNT_W'(MAX_BEATS + 1);

  always_comb begin
    if (remaining > MAX_C) begin
      // never leave a lone beat for the last piece
      if (remaining == TAIL_C) piece = PIECE_W'(MAX_BEATS - 1);
      else                     piece = PIECE_W'(MAX_BEATS);
    end else begin
      piece = remaining[PIECE_W-1:0];
    end
  end
endmodule

// File: rtl/burst_launch_gate.sv
module burst_launch_gate (
  input  logic rd_req,
  input  logic wr_req,
  input  logic rd_ready,
  input  logic wr_ready,
  output logic go,
  output logic go_rnw
);
  logic rd_ok, wr_ok;
  always_comb begin
    rd_ok  = rd_req & rd_ready;
    wr_ok  = wr_req & wr_ready;
    go     = rd_ok | wr_ok;
    go_rnw = rd_ok;
  end
endmodule

// File: rtl/burst_status_regs.sv
module burst_status_regs (
  input  logic clk,
  input  logic rst,
  input  logic ack_fire,
  input  logic timeout_fire,
  input  logic done_fire,
  input  logic err_seen,
  input  logic rnw,
  output logic ack_o,
  output logic cmplt_o,
  output logic error_o,
  output logic timeout_o,
  output logic rd_disc_o,
  output logic wr_disc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o     <= 1'b0;
      cmplt_o   <= 1'b0;
      error_o   <= 1'b0;
      timeout_o <= 1'b0;
      rd_disc_o <= 1'b0;
      wr_disc_o <= 1'b0;
    end else begin
      ack_o     <= ack_fire & ~timeout_fire;
      cmplt_o   <= timeout_fire | done_fire;
      error_o   <= timeout_fire | (done_fire & err_seen);
      timeout_o <= timeout_fire;
      rd_disc_o <= timeout_fire & rnw;
      wr_disc_o <= timeout_fire & ~rnw;
    end
  end
endmodule

// File: rtl/burst_cmd_splitter.sv
module burst_cmd_splitter #(
  parameter int ADDR_W       = 32,
  parameter int LEN_W        = 12,
  parameter int NATIVE_BYTES = 4,
  parameter int MAX_BEATS    = 16,
  parameter int PIECE_W      = $clog2(MAX_BEATS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_rd_req,
  input  logic                    cmd_wr_req,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [LEN_W-1:0]        cmd_len,
  input  logic                    cmd_burst,
  input  logic [NATIVE_BYTES-1:0] cmd_be,
  input  logic                    rd_dst_ready,
  input  logic                    wr_src_ready,
  output logic                    bus_req,
  output logic                    bus_rnw,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [NATIVE_BYTES-1:0] bus_be,
  output logic                    bus_burst,
  output logic [PIECE_W-1:0]      bus_beats,
  input  logic                    bus_addr_ack,
  input  logic                    bus_timeout,
  input  logic                    bus_data_done,
  input  logic                    bus_data_err,
  output logic                    st_cmd_ack,
  output logic                    st_cmplt,
  output logic                    st_error,
  output logic                    st_timeout,
  output logic                    rd_discontinue,
  output logic                    wr_discontinue
);
  import burst_cmd_pkg::*;

  localparam int BYTE_SHIFT = $clog2(NATIVE_BYTES);
  localparam int CNT_W      = LEN_W - BYTE_SHIFT + 1;

  ctl_state_t                state_q;
  logic                      rnw_q, burst_q, first_q, err_acc_q;
  logic [NATIVE_BYTES-1:0]   be_q;
  logic [ADDR_W-1:0]         addr_q;
  logic [CNT_W-1:0]          remain_q;
  logic [PIECE_W-1:0]        piece_q;

  logic                      go, go_rnw;
  logic [CNT_W-1:0]          init_beats, calc_in;
  logic [PIECE_W-1:0]        calc_piece;
  logic                      last_piece;
  logic                      ack_fire, to_fire, done_fire, err_seen;

  burst_launch_gate u_gate (
    .rd_req   (cmd_rd_req),
    .wr_req   (cmd_wr_req),
    .rd_ready (rd_dst_ready),
    .wr_ready (wr_src_ready),
    .go       (go),
    .go_rnw   (go_rnw)
  );

  always_comb begin
    init_beats = cmd_burst ? CNT_W'(cmd_len >> BYTE_SHIFT) : CNT_W'(1);
    calc_in    = (state_q == CTL_IDLE) ? init_beats
                                       : (remain_q - CNT_W'(piece_q));
    last_piece = (remain_q == CNT_W'(piece_q));
  end

  burst_piece_calc #(
    .MAX_BEATS (MAX_BEATS),
    .CNT_W     (CNT_W),
    .PIECE_W   (PIECE_W)
  ) u_calc (
    .remaining (calc_in),
    .piece     (calc_piece)
  );

  always_comb begin
    to_fire   = (state_q == CTL_REQ) & bus_timeout;
    ack_fire  = (state_q == CTL_REQ) & bus_addr_ack & ~bus_timeout & first_q;
    done_fire = (state_q == CTL_DATA) & bus_data_done & last_piece;
    err_seen  = err_acc_q | bus_data_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= CTL_IDLE;
      rnw_q     <= 1'b0;
      burst_q   <= 1'b0;
      first_q   <= 1'b0;
      err_acc_q <= 1'b0;
      be_q      <= '0;
      addr_q    <= '0;
      remain_q  <= '0;
      piece_q   <= '0;
    end else begin
      unique case (state_q)
        CTL_IDLE: begin
          if (go) begin
            state_q   <= CTL_REQ;
            rnw_q     <= go_rnw;
            burst_q   <= cmd_burst;
            be_q      <= cmd_burst ? '1 : cmd_be;
            addr_q    <= cmd_addr;
            remain_q  <= init_beats;
            piece_q   <= calc_piece;
            first_q   <= 1'b1;
            err_acc_q <= 1'b0;
          end
        end
        CTL_REQ: begin
          if (bus_timeout) begin
            state_q <= CTL_IDLE;
          end else if (bus_addr_ack) begin
            state_q <= CTL_DATA;
            first_q <= 1'b0;
          end
        end
        CTL_DATA: begin
          if (bus_data_done) begin
            err_acc_q <= err_seen;
            if (last_piece) begin
              state_q <= CTL_IDLE;
            end else begin
              state_q  <= CTL_REQ;
              addr_q   <= addr_q + (ADDR_W'(piece_q) << BYTE_SHIFT);
              remain_q <= remain_q - CNT_W'(piece_q);
              piece_q  <= calc_piece;
            end
          end
        end
        default: state_q <= CTL_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req   = (state_q == CTL_REQ);
    bus_rnw   = rnw_q;
    bus_addr  = addr_q;
    bus_be    = be_q;
    bus_burst = burst_q;
    bus_beats = piece_q;
  end

  burst_status_regs u_status (
    .clk          (clk),
    .rst          (rst),
    .ack_fire     (ack_fire),
    .timeout_fire (to_fire),
    .done_fire    (done_fire),
    .err_seen     (err_seen),
    .rnw          (rnw_q),
    .ack_o        (st_cmd_ack),
    .cmplt_o      (st_cmplt),
    .error_o      (st_error),
    .timeout_o    (st_timeout),
    .rd_disc_o    (rd_discontinue),
    .wr_disc_o    (wr_discontinue)
  );
endmodule

// File: rtl/burst_cmd_splitter_chk.sv
module burst_cmd_splitter_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 16,
  parameter int PIECE_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_req,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_burst,
  input logic [PIECE_W-1:0] bus_beats,
  input logic               bus_addr_ack,
  input logic               bus_timeout,
  input logic               st_cmd_ack,
  input logic               st_cmplt,
  input logic               st_error,
  input logic               st_timeout
);
  assert_ack_after_addr_ack_R3: assert property (@(posedge clk) disable iff (rst)
    st_cmd_ack |-> $past(bus_addr_ack));

  assert_ack_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    st_cmd_ack |=> !st_cmd_ack);

  assert_burst_beats_range_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_burst) |-> (bus_beats >= PIECE_W'(2) && bus_beats <= PIECE_W'(MAX_BEATS)));

  assert_cmplt_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    st_cmplt |=> !st_cmplt);

  assert_timeout_status_R8: assert property (@(posedge clk) disable iff (rst)
    st_timeout |-> (st_cmplt && st_error && !st_cmd_ack));

  assert_withdraw_after_timeout_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_timeout) |=> !bus_req);

  assert_hold_while_waiting_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_addr_ack && !bus_timeout) |=> (bus_req && $stable(bus_addr)));
endmodule

bind burst_cmd_splitter burst_cmd_splitter_chk #(
  .ADDR_W    (ADDR_W),
  .MAX_BEATS (MAX_BEATS),
  .PIECE_W   (PIECE_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_req      (bus_req),
  .bus_addr     (bus_addr),
  .bus_burst    (bus_burst),
  .bus_beats    (bus_beats),
  .bus_addr_ack (bus_addr_ack),
  .bus_timeout  (bus_timeout),
  .st_cmd_ack   (st_cmd_ack),
  .st_cmplt     (st_cmplt),
  .st_error     (st_error),
  .st_timeout   (st_timeout)
);

// File: tb/burst_cmd_splitter_tb_top.sv
module burst_cmd_splitter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_rd_req, cmd_wr_req, cmd_burst;
  logic [31:0] cmd_addr;
  logic [11:0] cmd_len;
  logic [3:0]  cmd_be;
  logic        rd_dst_ready, wr_src_ready;
  logic        bus_req, bus_rnw, bus_burst;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;
  logic [4:0]  bus_beats;
  logic        bus_addr_ack, bus_timeout, bus_data_done, bus_data_err;
  logic        st_cmd_ack, st_cmplt, st_error, st_timeout;
  logic        rd_discontinue, wr_discontinue;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_cmd_splitter dut_i (
    .clk(clk), .rst(rst),
    .cmd_rd_req(cmd_rd_req), .cmd_wr_req(cmd_wr_req),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_burst(cmd_burst), .cmd_be(cmd_be),
    .rd_dst_ready(rd_dst_ready), .wr_src_ready(wr_src_ready),
    .bus_req(bus_req), .bus_rnw(bus_rnw), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_burst(bus_burst), .bus_beats(bus_beats),
    .bus_addr_ack(bus_addr_ack), .bus_timeout(bus_timeout),
    .bus_data_done(bus_data_done), .bus_data_err(bus_data_err),
    .st_cmd_ack(st_cmd_ack), .st_cmplt(st_cmplt), .st_error(st_error),
    .st_timeout(st_timeout), .rd_discontinue(rd_discontinue), .wr_discontinue(wr_discontinue)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cmd_rd_req = 0; cmd_wr_req = 0; cmd_burst = 0; cmd_addr = '0; cmd_len = '0;
    cmd_be = '0; rd_dst_ready = 0; wr_src_ready = 0;
    bus_addr_ack = 0; bus_timeout = 0; bus_data_done = 0; bus_data_err = 0;
  endtask

  // Runs one command against a modelled bus. err_idx / to_idx select the child
  // whose data phase errors or whose address phase times out (-1 = none).
  task automatic run_cmd(input bit rd, input logic [31:0] a, input int beats,
                         input bit burst, input int err_idx, input int to_idx);
    int rem = burst ? beats : 1;
    logic [31:0] ea = a;
    int idx = 0;
    bit fin = 0;
    bit exp_err = 0;
    @(negedge clk);
    cmd_rd_req = rd; cmd_wr_req = !rd; cmd_addr = a; cmd_burst = burst;
    cmd_len = burst ? 12'(beats * NB) : 12'h0A4;
    cmd_be = 4'b0110; rd_dst_ready = rd; wr_src_ready = !rd;
    while (!fin) begin
      int n = 0;
      int exp_b;
      do begin @(negedge clk); n++; end while (!bus_req && n < 40);
      chk(bus_req, "R1", "bus_req raised", bus_req, 1);
      exp_b = (rem > 16) ? ((rem == 17) ? 15 : 16) : rem;
      chk(int'(bus_beats) == exp_b, burst ? "R4" : "R2", "bus_beats", bus_beats, exp_b);
      chk(bus_addr == ea, "R5", "bus_addr", bus_addr, ea);
      chk(bus_rnw == rd, "R2", "bus_rnw", bus_rnw, rd);
      chk(bus_burst == burst, "R2", "bus_burst", bus_burst, burst);
      chk(bus_be == (burst ? 4'hF : 4'b0110), burst ? "R6" : "R2", "bus_be",
          bus_be, burst ? 4'hF : 4'b0110);
      if (burst) chk(exp_b >= 2 && exp_b <= 16, "R6", "piece range", exp_b, 2);
      // hold one waiting cycle to see the request stay put
      @(negedge clk);
      chk(bus_req && bus_addr == ea, "R9", "held while waiting", bus_addr, ea);
      if (idx == to_idx) begin
        bus_timeout = 1;
        @(negedge clk);
        bus_timeout = 0;
        cmd_rd_req = 0; cmd_wr_req = 0;
        chk(!bus_req, "R9", "bus_req after timeout", bus_req, 0);
        chk(st_timeout && st_error && st_cmplt, "R8", "timeout status",
            {st_timeout, st_error, st_cmplt}, 3'b111);
        chk(!st_cmd_ack, "R8", "no ack on timeout", st_cmd_ack, 0);
        chk(rd_discontinue == rd && wr_discontinue == !rd, "R8", "discontinue",
            {rd_discontinue, wr_discontinue}, {rd, !rd});
        @(negedge clk);
        chk(!st_cmplt && !st_timeout, "R7", "status drops", {st_cmplt, st_timeout}, 0);
        fin = 1;
      end else begin
        bus_addr_ack = 1;
        @(negedge clk);
        bus_addr_ack = 0;
        chk(st_cmd_ack == (idx == 0), "R3", "cmd ack", st_cmd_ack, idx == 0);
        if (idx == 0) begin cmd_rd_req = 0; cmd_wr_req = 0; end
        chk(!bus_req, "R9", "bus_req after ack", bus_req, 0);
        @(negedge clk);
        chk(!st_cmd_ack, "R3", "ack one cycle", st_cmd_ack, 0);
        bus_data_done = 1;
        bus_data_err = (idx == err_idx);
        if (idx == err_idx) exp_err = 1;
        @(negedge clk);
        bus_data_done = 0; bus_data_err = 0;
        rem -= exp_b;
        ea += 32'(exp_b * NB);
        idx++;
        if (rem == 0) begin
          chk(st_cmplt, "R7", "complete pulse", st_cmplt, 1);
          chk(st_error == exp_err, "R7", "error with complete", st_error, exp_err);
          chk(!st_timeout, "R8", "no timeout", st_timeout, 0);
          @(negedge clk);
          chk(!st_cmplt && !bus_req, "R7", "complete one cycle", st_cmplt, 0);
          fin = 1;
        end else begin
          chk(!st_cmplt, "R7", "no early complete", st_cmplt, 0);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk({bus_req, st_cmd_ack, st_cmplt, st_error, st_timeout, rd_discontinue,
         wr_discontinue} == 0, "R10", "outputs after reset", bus_req, 0);
    chk(bus_beats == 0 && bus_addr == 0, "R10", "bus fields after reset", bus_beats, 0);

    // R1 readiness gate: wrong stream ready
    cmd_rd_req = 1; cmd_burst = 1; cmd_len = 12'd32; wr_src_ready = 1; rd_dst_ready = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!bus_req, "R1", "read held off", bus_req, 0);
    end
    cmd_rd_req = 0; cmd_wr_req = 1; wr_src_ready = 0; rd_dst_ready = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!bus_req, "R1", "write held off", bus_req, 0);
    end
    idle_inputs();
    @(negedge clk);
    // R1 read priority when both present and ready
    cmd_rd_req = 1; cmd_wr_req = 1; rd_dst_ready = 1; wr_src_ready = 1;
    cmd_burst = 0; cmd_be = 4'hC; cmd_addr = 32'h40;
    @(negedge clk);
    chk(bus_req && bus_rnw, "R1", "read wins", bus_rnw, 1);
    bus_addr_ack = 1;
    @(negedge clk);
    bus_addr_ack = 0; idle_inputs();
    @(negedge clk);
    bus_data_done = 1;
    @(negedge clk);
    bus_data_done = 0;
    chk(st_cmplt, "R7", "priority cmd complete", st_cmplt, 1);
    @(negedge clk);

    // R2 single beats
    run_cmd(1, 32'h1000_0004, 1, 0, -1, -1);
    run_cmd(0, 32'h1000_0008, 1, 0, 0, -1);

    // R4/R5/R6 sweep of burst sizes both directions
    for (int b = 2; b <= 40; b++) begin
      run_cmd(1, 32'h2000_0000 + 32'(b * 256), b, 1, -1, -1);
      run_cmd(0, 32'h3000_0010 + 32'(b * 256), b, 1, -1, -1);
    end
    // R7 error on first, middle child
    run_cmd(1, 32'h4000_0000, 40, 1, 0, -1);
    run_cmd(0, 32'h4000_1000, 40, 1, 1, -1);
    // R8 timeouts on first and on a child after the ack
    run_cmd(1, 32'h5000_0000, 8, 1, -1, 0);
    run_cmd(0, 32'h5000_0100, 1, 0, -1, 0);
    run_cmd(0, 32'h5000_1000, 40, 1, -1, 1);
    run_cmd(1, 32'h5000_2000, 33, 1, -1, 2);
    // full-length command
    run_cmd(1, 32'h6000_0000, 1023, 1, 60, -1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule